// File: doc/BRIEF.md
# Pulse-Position Tone Burst Encoder

This block produces the logic-level 22 kHz keying signal that a DC line modulator superimposes on the supply feeding an outdoor receive head. Steady tone on the line selects the high band and silence selects the low band. Tone can come from three places: a continuous-tone control bit that wins over everything else, a raw external gate that lets an outside controller key the carrier with its own timing, and an internal encoder. The encoder turns a short command message into pulse-position bits, where each bit occupies a 1.5 ms slot and its value is carried by how that slot divides into tone and silence.

The encoder also generates the two single-shot satellite-select bursts. Each burst fills a 12.5 ms window. One is unbroken tone. The other is a train of nine modulated '1' bits that stops after the tone portion of its ninth bit. All timing comes from counters that divide the system clock, and both frequencies are set by parameters. The carrier always begins in its low half when it is gated on, so every burst has the same leading edge.

Top module: `tone_burst_encoder`

## Requirements
- R1: The carrier is a square wave whose half period is round(CLK_HZ / (2*TONE_HZ)) clock cycles. Every high phase lasts exactly one half period while the gate stays on. After the gate turns on, the first high phase begins one full half period later.
- R2: The time unit is CLK_HZ/2000 cycles (0.5 ms). A '0' bit is two units of gated tone followed by one unit of silence.
- R3: A '1' bit is one unit of gated tone followed by two units of silence.
- R4: While cont_tone_en is 1, the carrier runs without a break, whatever ext_gate does.
- R5: While cont_tone_en is 0, ext_gate at 1 keys the carrier directly. Every cycle the gate is held counts toward the carrier.
- R6: After reset, and whenever no source requests tone, tone_out is 0. Reset also clears busy and done.
- R7: A message is msg_len bytes taken from msg_data. Byte 0 is bits [7:0], byte 1 is bits [15:8], and so on. Each byte is sent most significant bit first and is followed by an odd-parity bit (the nine bits hold an odd number of ones). The parity bit uses the same bit encoding.
- R8: A pulse on burst_a_go starts a burst of unbroken gated tone lasting 25 units (12.5 ms).
- R9: A pulse on burst_b_go starts nine '1' bits. The burst ends after the tone unit of the ninth bit, so it also lasts 25 units.
- R10: busy is 1 in the cycle after a command is accepted and stays 1 until the command finishes. A msg_start, burst_a_go or burst_b_go that arrives while busy is 1 is ignored and does not change the output sequence.
- R11: done is a single-cycle pulse. It is raised in the cycle right after the last unit of the command: 27*msg_len units after acceptance for a message, and 25 units for either burst. busy is 0 in that same cycle.
- R12: A msg_start with msg_len = 0 is ignored. When several commands arrive together while idle, msg_start wins, then burst_a_go, then burst_b_go.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cont_tone_en | input | 1 | Forces continuous carrier |
| ext_gate | input | 1 | Raw external tone gate |
| msg_data | input | 8*MAX_BYTES | Message bytes, byte 0 in the low eight bits |
| msg_len | input | clog2(MAX_BYTES+1) | Number of message bytes |
| msg_start | input | 1 | Start strobe for a message |
| burst_a_go | input | 1 | Start the unbroken select burst |
| burst_b_go | input | 1 | Start the modulated select burst |
| tone_out | output | 1 | Gated carrier square wave |
| busy | output | 1 | Encoder is running a command |
| done | output | 1 | One-cycle completion pulse |

## Verification
The assertions check on every cycle that an idle encoder with no request leaves the line silent, that no high phase starts before a full low half period has passed, that accepted commands raise busy on the next cycle, and that done is a lone pulse that closes a busy period. Other properties depend on long stretches of time and can only be shown by the bench scenarios: whether a bit's tone-to-silence split decodes to the right value, byte order and parity, the length of both select bursts, the exact cycle in which done appears, and whether the carrier stays unbroken under the continuous bit while the external gate toggles. The bench's monitor counts carrier pulses per burst to recover each bit.

// File: rtl/tone_burst_encoder.sv
module tone_burst_encoder #(
  parameter int CLK_HZ      = 27_000_000,
  parameter int TONE_HZ     = 22_000,
  parameter int UNIT_HZ     = 2_000,
  parameter int MAX_BYTES   = 6,
  parameter int SEL_B_BITS  = 9
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           cont_tone_en,
  input  logic                           ext_gate,
  input  logic [MAX_BYTES*8-1:0]         msg_data,
  input  logic [$clog2(MAX_BYTES+1)-1:0] msg_len,
  input  logic                           msg_start,
  input  logic                           burst_a_go,
  input  logic                           burst_b_go,
  output logic                           tone_out,
  output logic                           busy,
  output logic                           done
);

  localparam int HALF_CYC = (CLK_HZ + TONE_HZ) / (2 * TONE_HZ);
  localparam int UNIT_CYC = CLK_HZ / UNIT_HZ;
  localparam int HALF_W   = $clog2(HALF_CYC + 1);
  localparam int UNIT_W   = $clog2(UNIT_CYC + 1);
  localparam int LEN_W    = $clog2(MAX_BYTES + 1);
  localparam int POS_MAX  = (SEL_B_BITS > 9) ? SEL_B_BITS : 9;
  localparam int POS_W    = $clog2(POS_MAX + 1);
  localparam logic [POS_W-1:0] PAR_POS = POS_W'(8);
  localparam logic [POS_W-1:0] B_LAST  = POS_W'(SEL_B_BITS - 1);

  typedef enum logic [1:0] {S_IDLE, S_MSG, S_BA, S_BB} state_t;

  state_t                 st;
  logic [UNIT_W-1:0]      unit_cnt;
  logic [1:0]             slot;
  logic [POS_W-1:0]       pos;
  logic [LEN_W-1:0]       bytes_left;
  logic [MAX_BYTES*8-1:0] shreg;
  logic                   done_q;
  logic [HALF_W-1:0]      tone_cnt;
  logic                   tone_q;

  logic unit_end, last_unit, cur_bit, enc_gate, gate;
  logic [2:0] bsel;

  assign unit_end = (unit_cnt == UNIT_W'(UNIT_CYC - 1));
  assign bsel     = 3'd7 - pos[2:0];
  assign cur_bit  = (pos == PAR_POS) ? ~(^shreg[7:0]) : shreg[bsel];

  always_comb begin
    case (st)
      S_MSG:   last_unit = (pos == PAR_POS) && (slot == 2'd2) && (bytes_left == LEN_W'(1));
      S_BA,
      S_BB:    last_unit = (pos == B_LAST) && (slot == 2'd0);
      default: last_unit = 1'b0;
    endcase
  end

  always_comb begin
    case (st)
      S_MSG:   enc_gate = (slot == 2'd0) || ((slot == 2'd1) && !cur_bit);
      S_BA:    enc_gate = 1'b1;
      S_BB:    enc_gate = (slot == 2'd0);
      default: enc_gate = 1'b0;
    endcase
  end

  assign gate = cont_tone_en | ext_gate | enc_gate;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st         <= S_IDLE;
      unit_cnt   <= '0;
      slot       <= '0;
      pos        <= '0;
      bytes_left <= '0;
      shreg      <= '0;
      done_q     <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (st == S_IDLE) begin
        unit_cnt <= '0;
        slot     <= '0;
        pos      <= '0;
        if (msg_start && (msg_len != '0)) begin
          st         <= S_MSG;
          shreg      <= msg_data;
          bytes_left <= msg_len;
        end else if (burst_a_go) begin
          st <= S_BA;
        end else if (burst_b_go) begin
          st <= S_BB;
        end
      end else if (!unit_end) begin
        unit_cnt <= unit_cnt + 1'b1;
      end else begin
        unit_cnt <= '0;
        if (last_unit) begin
          st     <= S_IDLE;
          done_q <= 1'b1;
        end else if (slot != 2'd2) begin
          slot <= slot + 1'b1;
        end else begin
          slot <= '0;
          if (st == S_MSG && pos == PAR_POS) begin
            pos        <= '0;
            bytes_left <= bytes_left - 1'b1;
            shreg      <= shreg >> 8;
          end else begin
            pos <= pos + 1'b1;
          end
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !gate) begin
      tone_cnt <= '0;
      tone_q   <= 1'b0;
    end else if (tone_cnt == HALF_W'(HALF_CYC - 1)) begin
      tone_cnt <= '0;
      tone_q   <= ~tone_q;
    end else begin
      tone_cnt <= tone_cnt + 1'b1;
    end
  end

  assign tone_out = tone_q;
  assign busy     = (st != S_IDLE);
  assign done     = done_q;

endmodule

// File: rtl/tone_burst_encoder_chk.sv
module tone_burst_encoder_chk #(
  parameter int CLK_HZ    = 27_000_000,
  parameter int TONE_HZ   = 22_000,
  parameter int MAX_BYTES = 6
) (
  input logic                           clk,
  input logic                           rst_n,
  input logic                           cont_tone_en,
  input logic                           ext_gate,
  input logic                           msg_start,
  input logic                           burst_a_go,
  input logic                           burst_b_go,
  input logic [$clog2(MAX_BYTES+1)-1:0] msg_len,
  input logic                           tone_out,
  input logic                           busy,
  input logic                           done
);

  localparam int HALF_CYC = (CLK_HZ + TONE_HZ) / (2 * TONE_HZ);
  localparam int RUN_W    = $clog2(HALF_CYC + 1);

  logic [RUN_W-1:0] low_run;

  always_ff @(posedge clk) begin
    if (!rst_n || tone_out) low_run <= '0;
    else if (low_run != RUN_W'(HALF_CYC)) low_run <= low_run + 1'b1;
  end

  AST_LOW_PHASE_MIN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tone_out) |-> (low_run == RUN_W'(HALF_CYC))); // R1

  AST_IDLE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !cont_tone_en && !ext_gate) |=> !tone_out); // R6

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R11

  AST_DONE_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy))); // R11

  AST_MSG_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && msg_start && (msg_len != '0)) |=> busy); // R10

  AST_BURST_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && (burst_a_go || burst_b_go)) |=> busy); // R10

endmodule

bind tone_burst_encoder tone_burst_encoder_chk #(
  .CLK_HZ(CLK_HZ), .TONE_HZ(TONE_HZ), .MAX_BYTES(MAX_BYTES)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cont_tone_en(cont_tone_en), .ext_gate(ext_gate),
  .msg_start(msg_start), .burst_a_go(burst_a_go), .burst_b_go(burst_b_go),
  .msg_len(msg_len), .tone_out(tone_out), .busy(busy), .done(done)
);

// File: tb/sim_tone_burst_encoder.sv
`timescale 1ns/1ps
module sim_tone_burst_encoder;

  localparam int CLK_HZ = 440_000;
  localparam int HALF   = 10;
  localparam int UNIT   = 220;
  localparam int GAP    = 3 * HALF;

  logic clk = 0, rst_n = 0, cont_tone_en = 0, ext_gate = 0;
  logic [47:0] msg_data = '0;
  logic [2:0]  msg_len = '0;
  logic msg_start = 0, burst_a_go = 0, burst_b_go = 0;
  logic tone_out, busy, done;

  int checks = 0, fails = 0;
  bit finished = 0;
  int    exp_q[$];
  string req_q[$];

  always #2 clk = ~clk;

  tone_burst_encoder #(.CLK_HZ(CLK_HZ)) u0 (
    .clk(clk), .rst_n(rst_n), .cont_tone_en(cont_tone_en), .ext_gate(ext_gate),
    .msg_data(msg_data), .msg_len(msg_len), .msg_start(msg_start),
    .burst_a_go(burst_a_go), .burst_b_go(burst_b_go),
    .tone_out(tone_out), .busy(busy), .done(done)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // scoreboard monitor: one item per gated burst = expected carrier pulse count
  int  hi_w = 0, lo_w = 0, pulses = 0, bad_w = 0;
  bit  prev = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (tone_out) begin
        hi_w++;
        lo_w = 0;
      end else begin
        if (prev) begin
          pulses++;
          if (hi_w != HALF) bad_w++;
          hi_w = 0;
        end
        lo_w++;
        if (lo_w == GAP && pulses > 0) begin
          if (exp_q.size() == 0) begin
            check(0, "unexpected burst", pulses, 0);
          end else begin
            automatic int    e = exp_q.pop_front();
            automatic string r = req_q.pop_front();
            check(pulses == e, r, pulses, e);
            check(bad_w == 0, "R1 half period", bad_w, 0);
          end
          pulses = 0;
          bad_w  = 0;
        end
      end
      prev = tone_out;
    end
  end

  task automatic push(input int n, input string r);
    exp_q.push_back(n);
    req_q.push_back(r);
  endtask

  task automatic push_byte(input logic [7:0] b, input string r);
    for (int i = 7; i >= 0; i--) push(b[i] ? 11 : 22, b[i] ? {r, "/R3"} : {r, "/R2"});
    push((~^b) ? 11 : 22, {r, "/R7 parity"});
  endtask

  // kind: 0 message, 1 burst A, 2 burst B, 3 message + burst B together
  task automatic run_cmd(input int kind, input logic [47:0] data, input int len,
                         input int units, input bit inject, input string r);
    int n;
    @(negedge clk);
    msg_data = data;
    msg_len  = 3'(len);
    msg_start  = (kind == 0 || kind == 3);
    burst_a_go = (kind == 1);
    burst_b_go = (kind == 2 || kind == 3);
    @(negedge clk);
    msg_start = 0; burst_a_go = 0; burst_b_go = 0;
    check(busy == 1'b1, "R10 busy after accept", busy, 1);
    n = 0;
    while (!done && n < units * UNIT + 100) begin
      @(negedge clk);
      n++;
      if (inject && n == 1000) begin
        msg_start = 1; burst_a_go = 1; msg_data = '1; msg_len = 3'd1;
      end
      if (inject && n == 1001) begin
        msg_start = 0; burst_a_go = 0;
        check(busy == 1'b1, "R10 busy mid command", busy, 1);
      end
    end
    check(n == units * UNIT, {r, "/R11 done cycle"}, n, units * UNIT);
    @(negedge clk);
    check(done == 1'b0 && busy == 1'b0, "R11 single done pulse", {done, busy}, 0);
    repeat (60) @(negedge clk);
    check(exp_q.size() == 0, {r, " all bursts seen"}, exp_q.size(), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("[TB] %0d tests run, %0d failed", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(tone_out == 0 && busy == 0 && done == 0, "R6 reset state", {tone_out, busy, done}, 0);
    rst_n = 1;
    @(negedge clk);
    check(tone_out == 0 && busy == 0 && done == 0, "R6 after reset", {tone_out, busy, done}, 0);

    begin
      int highs = 0;
      repeat (300) begin @(negedge clk); if (tone_out) highs++; end
      check(highs == 0, "R6 idle silence", highs, 0);
    end

    // R5: external gate keys carrier for 200 cycles -> 10 pulses
    push(10, "R5 external gate");
    @(negedge clk); ext_gate = 1;
    repeat (200) @(negedge clk);
    ext_gate = 0;
    repeat (60) @(negedge clk);
    check(exp_q.size() == 0, "R5 burst seen", exp_q.size(), 0);

    // R4: continuous bit with ext_gate toggling -> one unbroken run of 20 pulses
    push(20, "R4 continuous override");
    @(negedge clk); cont_tone_en = 1;
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      ext_gate = ((i % 20) < 7);
    end
    cont_tone_en = 0; ext_gate = 0;
    repeat (60) @(negedge clk);
    check(exp_q.size() == 0, "R4 burst seen", exp_q.size(), 0);

    push_byte(8'hA5, "R7 byte A5");
    run_cmd(0, 48'h0000_0000_00A5, 1, 27, 0, "R7 one byte");

    // R10: start and burst during a two-byte message are ignored
    push_byte(8'h01, "R7 byte0");
    push_byte(8'hFF, "R7 byte1");
    run_cmd(0, 48'h0000_0000_FF01, 2, 54, 1, "R10 ignore while busy");

    push(275, "R8 burst A");
    run_cmd(1, '0, 0, 25, 0, "R8 burst A");

    for (int i = 0; i < 9; i++) push(11, "R9 burst B bit");
    run_cmd(2, '0, 0, 25, 0, "R9 burst B");

    // R12: zero-length start ignored
    @(negedge clk); msg_len = 3'd0; msg_start = 1;
    @(negedge clk); msg_start = 0;
    check(busy == 1'b0, "R12 zero length ignored", busy, 0);
    repeat (60) @(negedge clk);
    check(busy == 1'b0 && tone_out == 1'b0, "R12 stays idle", {busy, tone_out}, 0);

    // R12: message wins over simultaneous burst B
    push_byte(8'h3C, "R12 priority");
    run_cmd(3, 48'h0000_0000_003C, 1, 27, 0, "R12 priority");

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

endmodule